// File: doc/BRIEF.md
# Two-Stage Shift-Add Inner Product Unit

This block forms the dot product of a bank of signed 16-bit weights with 16 activations. No activation is ever presented as a binary word. Each lane receives its activation as a serial stream of power-of-two terms. A term carries a 4-bit bit position (offset) and a sign flag. A lane's activation equals the sum of its terms, each worth plus or minus two raised to its offset. Only the non-zero terms are sent, so the number of cycles a run takes follows the number of terms rather than the word width. Terms may also be negative, which lets a run of ones in the activation be sent as just two terms.

The block does no multiplication. In every cycle it finds the smallest pending offset among the lanes that have a term waiting, and uses it as a common base. A lane issues its term only when the term's offset is less than 2^N above the base (N = 2 by default). An issuing lane shifts its weight left by that small relative amount and negates the result for a negative term. The lane values are added in a balanced tree. One shared shifter then moves the tree sum left by the base, and the result is added into a wide signed accumulator. A lane whose term falls outside the window holds that term and tries again in a later cycle.

A run is controlled by a three-state machine. IDLE moves to RUN when start is accepted. RUN moves to DONE in the cycle in which every lane has consumed its last term. DONE returns to IDLE, or moves straight back to RUN if start is high again. The result is flagged valid for the single cycle spent in DONE.

Top module: `spip_shift_add_dot`

## Requirements
- R1: After reset, result_valid and every term_ready bit are low and result reads zero.
- R2: When a run ends, result equals the sum over lanes of weight times activation. A lane's activation is the sum of its terms, each worth +2^off, or -2^off when the sign flag is 1. The offset of lane l sits in term_off bits [4l+3:4l] and its weight in wt_in bits [16l+15:16l].
- R3: A lane consumes at most one term per cycle. A term is consumed exactly in a cycle where term_valid and term_ready are both high, and terms are consumed in stream order.
- R4: In each RUN cycle the base is the smallest offset among the lanes that are still unfinished and present a valid term. Exactly those lanes whose offset minus the base is below 2^N (4 by default) are given ready.
- R5: A lane whose term lies outside the window keeps ready low and contributes nothing that cycle. Two lanes with terms {0,1,2} and {8} therefore take 4 cycles, while {0,1,2} and {3} take 3.
- R6: result_valid is high for exactly one cycle. That cycle follows the cycle in which the last unfinished lane consumed its final term, which is flagged by term_last.
- R7: Start, accepted outside RUN, clears the accumulator and samples act_empty. A lane flagged empty counts as finished at once and never raises ready, even if it drives term_valid. If all lanes are empty, the run ends after one RUN cycle with result zero.
- R8: Weights are captured only when wt_load is high and are kept across any number of runs.
- R9: A negative term subtracts its shifted weight, so an activation of 15 may be sent as +2^4 and -2^0.
- R10: The accumulator is 40 bits and signed. Sixteen lanes of weight -32768 with activation 65535 give exactly -34359214080.
- R11: The run length, counted from the start edge to the DONE state, equals the number of cycles in which terms issue, and is at least one. All-ones activations on every lane take 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_load | input | 1 | Capture wt_in into the weight register |
| wt_in | input | 256 | Sixteen signed 16-bit weights, lane l at bits [16l+15:16l] |
| start | input | 1 | Begin a run (taken in IDLE or DONE) |
| act_empty | input | 16 | Lane has no terms for this run, sampled with start |
| term_valid | input | 16 | Lane presents a term |
| term_off | input | 64 | 4-bit term offset per lane |
| term_neg | input | 16 | Term is negative |
| term_last | input | 16 | Term is the lane's final one |
| term_ready | output | 16 | Lane's term is consumed this cycle |
| result | output | 40 | Signed accumulator contents |
| result_valid | output | 1 | One-cycle flag that result is final |

## Verification
The assertions check on every cycle that ready appears only in RUN and that some lane makes progress whenever any lane has a term pending. They also check that lanes flagged empty stay silent, that the valid flag lasts one cycle and follows completion, and that the accumulator add never overflows. The bench's scenarios are needed to show the arithmetic: the final sums for random, all-ones, negative-term and extreme-weight activations. Only the scenarios can also show the exact cycle cost of a window stall, the clearing of the accumulator between runs, and the fact that weights are kept across runs.

// File: rtl/spip_pkg.sv
package spip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } spip_state_e;
endpackage

// File: rtl/spip_window_sched.sv
// Picks the common base offset and the set of lanes whose head term fits the window.
module spip_window_sched #(
    parameter int LANES = 16,
    parameter int OFF_W = 4,
    parameter int N_REL = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       pend,
    input  logic [LANES*OFF_W-1:0] off_flat,
    output logic [OFF_W-1:0]       base,
    output logic [LANES-1:0]       issue,
    output logic [LANES*N_REL-1:0] rel_flat
);
    localparam int WIN = 1 << N_REL;

    logic [OFF_W-1:0] diff [LANES];

    always_comb begin
        base = '1;
        for (int l = 0; l < LANES; l++) begin
            if (pend[l] && (off_flat[l*OFF_W +: OFF_W] < base)) begin
                base = off_flat[l*OFF_W +: OFF_W];
            end
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign diff[l]                   = off_flat[l*OFF_W +: OFF_W] - base;
            assign issue[l]                  = pend[l] && (32'(diff[l]) < WIN);
            assign rel_flat[l*N_REL +: N_REL] = diff[l][N_REL-1:0];
        end
    endgenerate

    AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (|issue)); // R4

    AST_ISSUE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue & ~pend) == '0)); // R3
endmodule

// File: rtl/spip_lane_shift.sv
// First-stage shifter: weight moved by a small relative offset, optionally negated.
module spip_lane_shift #(
    parameter int W_W    = 16,
    parameter int N_REL  = 2,
    parameter int LANE_W = 20
) (
    input  logic [W_W-1:0]    weight,
    input  logic [N_REL-1:0]  rel,
    input  logic              neg,
    input  logic              en,
    output logic [LANE_W-1:0] lane_val
);
    logic signed [LANE_W-1:0] wide;
    logic signed [LANE_W-1:0] shifted;

    assign wide    = {{(LANE_W-W_W){weight[W_W-1]}}, weight};
    assign shifted = wide <<< rel;

    always_comb begin
        if (!en) begin
            lane_val = '0;
        end else if (neg) begin
            lane_val = -shifted;
        end else begin
            lane_val = shifted;
        end
    end
endmodule

// File: rtl/spip_sum_tree.sv
// Balanced adder tree over all lane values.
module spip_sum_tree #(
    parameter int LANES  = 16,
    parameter int LANE_W = 20,
    parameter int SUM_W  = 24
) (
    input  logic [LANES*LANE_W-1:0] lane_flat,
    output logic [SUM_W-1:0]        total
);
    localparam int LVL = $clog2(LANES);

    generate
        for (genvar k = 0; k <= LVL; k++) begin : g_lvl
            logic [SUM_W-1:0] node [LANES >> k];
            if (k == 0) begin : g_leaf
                for (genvar i = 0; i < LANES; i++) begin : g_in
                    assign node[i] = {{(SUM_W-LANE_W){lane_flat[i*LANE_W+LANE_W-1]}},
                                      lane_flat[i*LANE_W +: LANE_W]};
                end
            end else begin : g_add
                for (genvar i = 0; i < (LANES >> k); i++) begin : g_pair
                    assign node[i] = g_lvl[k-1].node[2*i] + g_lvl[k-1].node[2*i+1];
                end
            end
        end
    endgenerate

    assign total = g_lvl[LVL].node[0];
endmodule

// File: rtl/spip_shift_add_dot.sv
module spip_shift_add_dot #(
    parameter int LANES = 16,
    parameter int W_W   = 16,
    parameter int OFF_W = 4,
    parameter int N_REL = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wt_load,
    input  logic [LANES*W_W-1:0]   wt_in,
    input  logic                   start,
    input  logic [LANES-1:0]       act_empty,
    input  logic [LANES-1:0]       term_valid,
    input  logic [LANES*OFF_W-1:0] term_off,
    input  logic [LANES-1:0]       term_neg,
    input  logic [LANES-1:0]       term_last,
    output logic [LANES-1:0]       term_ready,
    output logic [W_W+(1<<OFF_W)+$clog2(LANES)+3:0] result,
    output logic                   result_valid
);
    import spip_pkg::*;

    localparam int WIN    = 1 << N_REL;
    localparam int S1_W   = W_W + WIN - 1;
    localparam int LANE_W = S1_W + 1;
    localparam int SUM_W  = LANE_W + $clog2(LANES);
    localparam int ACC_W  = W_W + (1 << OFF_W) + $clog2(LANES) + 4;

    spip_state_e state_q, state_d;

    logic [LANES*W_W-1:0]    wt_q;
    logic [LANES-1:0]        done_q;
    logic [ACC_W-1:0]        acc_q;
    logic                    run;
    logic                    take_start;
    logic [LANES-1:0]        pend;
    logic [LANES-1:0]        issue;
    logic [LANES-1:0]        fin_now;
    logic [OFF_W-1:0]        base;
    logic [LANES*N_REL-1:0]  rel_flat;
    logic [LANES*LANE_W-1:0] lane_flat;
    logic [SUM_W-1:0]        tree_sum;
    logic signed [ACC_W-1:0] sum_ext;
    logic signed [ACC_W-1:0] stage2;
    logic [ACC_W:0]          acc_wide;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if ((done_q | fin_now) == '1) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        run          = (state_q == ST_RUN);
        take_start   = start && (state_q != ST_RUN);
        result_valid = (state_q == ST_DONE);
        term_ready   = issue;
        result       = acc_q;
    end

    assign pend    = {LANES{run}} & ~done_q & term_valid;
    assign fin_now = issue & term_last;

    // ---------------- scheduling ----------------
    spip_window_sched #(
        .LANES (LANES),
        .OFF_W (OFF_W),
        .N_REL (N_REL)
    ) i_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .off_flat (term_off),
        .base     (base),
        .issue    (issue),
        .rel_flat (rel_flat)
    );

    // ---------------- first-stage shifters ----------------
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            spip_lane_shift #(
                .W_W    (W_W),
                .N_REL  (N_REL),
                .LANE_W (LANE_W)
            ) i_shift (
                .weight   (wt_q[l*W_W +: W_W]),
                .rel      (rel_flat[l*N_REL +: N_REL]),
                .neg      (term_neg[l]),
                .en       (issue[l]),
                .lane_val (lane_flat[l*LANE_W +: LANE_W])
            );
        end
    endgenerate

    spip_sum_tree #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .SUM_W  (SUM_W)
    ) i_tree (
        .lane_flat (lane_flat),
        .total     (tree_sum)
    );

    // ---------------- second-stage shift and accumulate ----------------
    assign sum_ext  = {{(ACC_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};
    assign stage2   = sum_ext <<< base;
    assign acc_wide = {acc_q[ACC_W-1], acc_q} + {stage2[ACC_W-1], stage2};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else if (wt_load) begin
            wt_q <= wt_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= '1;
        end else if (take_start) begin
            acc_q  <= '0;
            done_q <= act_empty;
        end else if (run) begin
            acc_q  <= acc_wide[ACC_W-1:0];
            done_q <= done_q | fin_now;
        end
    end

    // ---------------- assertions ----------------
    AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (|term_ready) |-> (state_q == ST_RUN)); // R3

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        take_start |=> ((term_ready & $past(act_empty)) == '0)); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ((done_q | fin_now) == '1)) |=> result_valid); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_wide[ACC_W] == acc_wide[ACC_W-1])); // R10

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !start) |=> $stable(result)); // R6
endmodule

// File: tb/test_spip_shift_add_dot.sv
module test_spip_shift_add_dot;
    localparam int LANES = 16;
    localparam int W_W   = 16;
    localparam int OFF_W = 4;
    localparam int ACC_W = 40;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wt_load = 1'b0;
    logic [LANES*W_W-1:0]   wt_in = '0;
    logic                   start = 1'b0;
    logic [LANES-1:0]       act_empty = '0;
    logic [LANES-1:0]       term_valid = '0;
    logic [LANES*OFF_W-1:0] term_off = '0;
    logic [LANES-1:0]       term_neg = '0;
    logic [LANES-1:0]       term_last = '0;
    logic [LANES-1:0]       term_ready;
    logic [ACC_W-1:0]       result;
    logic                   result_valid;

    spip_shift_add_dot i_spip_shift_add_dot (
        .clk          (clk),
        .rst_n        (rst_n),
        .wt_load      (wt_load),
        .wt_in        (wt_in),
        .start        (start),
        .act_empty    (act_empty),
        .term_valid   (term_valid),
        .term_off     (term_off),
        .term_neg     (term_neg),
        .term_last    (term_last),
        .term_ready   (term_ready),
        .result       (result),
        .result_valid (result_valid)
    );

    always #5 clk = ~clk;

    int     nchk = 0;
    int     nerr = 0;
    int     wgt   [LANES];
    int     t_off [LANES][32];
    bit     t_neg [LANES][32];
    int     t_cnt [LANES];
    bit     ghost [LANES];
    int     idx   [LANES];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic clear_terms();
        for (int l = 0; l < LANES; l++) begin
            t_cnt[l] = 0;
            ghost[l] = 1'b0;
        end
    endtask

    task automatic add_term(input int l, input int off, input bit neg);
        t_off[l][t_cnt[l]] = off;
        t_neg[l][t_cnt[l]] = neg;
        t_cnt[l]++;
    endtask

    task automatic add_value(input int l, input int a);
        for (int b = 0; b < 16; b++) begin
            if (a[b]) add_term(l, b, 1'b0);
        end
    endtask

    task automatic load_weights();
        @(negedge clk);
        wt_load = 1'b1;
        for (int l = 0; l < LANES; l++) wt_in[l*W_W +: W_W] = W_W'(wgt[l]);
        @(negedge clk);
        wt_load = 1'b0;
        wt_in   = '0;
    endtask

    task automatic drive_terms();
        for (int l = 0; l < LANES; l++) begin
            act_empty[l] = (t_cnt[l] == 0);
            if (ghost[l]) begin
                term_valid[l] = 1'b1;
                term_off[l*OFF_W +: OFF_W] = '0;
                term_neg[l]  = 1'b0;
                term_last[l] = 1'b1;
            end else if (idx[l] < t_cnt[l]) begin
                term_valid[l] = 1'b1;
                term_off[l*OFF_W +: OFF_W] = OFF_W'(t_off[l][idx[l]]);
                term_neg[l]  = t_neg[l][idx[l]];
                term_last[l] = (idx[l] == t_cnt[l] - 1);
            end else begin
                term_valid[l] = 1'b0;
                term_off[l*OFF_W +: OFF_W] = '0;
                term_neg[l]  = 1'b0;
                term_last[l] = 1'b0;
            end
        end
    endtask

    // Runs the loaded terms; checks sum, optional cycle count, pulse width, ghost lanes.
    task automatic run_case(input string req, input string name, input int exp_cyc);
        longint exp_sum = 0;
        logic [ACC_W-1:0] exp_vec;
        logic [LANES-1:0] rdy_prev = '0;
        bit finished = 1'b0;
        bit ghost_hit = 1'b0;
        int cyc = 0;
        for (int l = 0; l < LANES; l++) begin
            longint a = 0;
            for (int t = 0; t < t_cnt[l]; t++) begin
                if (t_neg[l][t]) a -= (64'sd1 <<< t_off[l][t]);
                else             a += (64'sd1 <<< t_off[l][t]);
            end
            exp_sum += longint'(wgt[l]) * a;
            idx[l] = 0;
        end
        exp_vec = ACC_W'(exp_sum);
        @(negedge clk);
        start = 1'b1;
        drive_terms();
        @(negedge clk);
        start = 1'b0;
        while (!finished && cyc < 3000) begin
            cyc++;
            for (int l = 0; l < LANES; l++) if (rdy_prev[l]) idx[l]++;
            if (result_valid) begin
                finished = 1'b1;
            end else begin
                drive_terms();
                #1;
                rdy_prev = term_ready;
                for (int l = 0; l < LANES; l++) if (ghost[l] && term_ready[l]) ghost_hit = 1'b1;
                @(negedge clk);
            end
        end
        check(finished, req, {name, " completion"}, cyc, 0);
        check(result == exp_vec, req, {name, " sum"}, $signed(result), exp_sum);
        if (exp_cyc >= 0) check(cyc - 1 == exp_cyc, "R11", {name, " cycles"}, cyc - 1, exp_cyc);
        check(!ghost_hit, "R7", {name, " empty lane silent"}, ghost_hit, 0);
        term_valid = '0;
        @(negedge clk);
        check(!result_valid, "R6", {name, " valid one cycle"}, result_valid, 0);
    endtask

    task automatic t_reset();
        check(!result_valid, "R1", "reset valid", result_valid, 0);
        check(term_ready == '0, "R1", "reset ready", term_ready, 0);
        check(result == '0, "R1", "reset result", result, 0);
    endtask

    task automatic t_basic();
        for (int l = 0; l < LANES; l++) wgt[l] = l * 37 - 300;
        load_weights();
        clear_terms();
        for (int l = 0; l < LANES; l++) add_value(l, l + 3);
        run_case("R2", "basic", -1);
    endtask

    task automatic t_random();
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < LANES; l++) wgt[l] = int'($signed(16'($urandom)));
            load_weights();
            clear_terms();
            for (int l = 0; l < LANES; l++) add_value(l, int'($urandom & 32'hFFFF));
            run_case("R3", "random", -1);
        end
    endtask

    task automatic t_all_ones();
        for (int l = 0; l < LANES; l++) wgt[l] = int'($signed(16'($urandom)));
        load_weights();
        clear_terms();
        for (int l = 0; l < LANES; l++) add_value(l, 16'hFFFF);
        run_case("R2", "all ones", 16);
    endtask

    task automatic t_window();
        for (int l = 0; l < LANES; l++) wgt[l] = 1000 + l;
        load_weights();
        clear_terms();
        add_term(0, 0, 0); add_term(0, 1, 0); add_term(0, 2, 0);
        add_term(1, 8, 0);
        run_case("R5", "window stall", 4);
        clear_terms();
        add_term(0, 0, 0); add_term(0, 1, 0); add_term(0, 2, 0);
        add_term(1, 3, 0);
        run_case("R4", "window fit", 3);
    endtask

    task automatic t_negative();
        for (int l = 0; l < LANES; l++) wgt[l] = -77 + 5 * l;
        load_weights();
        clear_terms();
        add_term(0, 4, 0); add_term(0, 0, 1);
        add_term(1, 3, 1); add_term(1, 5, 0);
        add_term(2, 0, 1);
        run_case("R9", "negative terms", 3);
    endtask

    task automatic t_empty();
        clear_terms();
        run_case("R7", "all empty", 1);
        clear_terms();
        ghost[0] = 1'b1;
        add_value(1, 9);
        run_case("R7", "ghost lane", -1);
    endtask

    task automatic t_extreme();
        for (int l = 0; l < LANES; l++) wgt[l] = -32768;
        load_weights();
        clear_terms();
        for (int l = 0; l < LANES; l++) add_value(l, 16'hFFFF);
        run_case("R10", "extreme", 16);
    endtask

    task automatic t_reuse();
        for (int l = 0; l < LANES; l++) wgt[l] = 2 * l - 11;
        load_weights();
        clear_terms();
        for (int l = 0; l < LANES; l++) add_value(l, 200 + l);
        run_case("R8", "reuse first", -1);
        wt_in = '1;
        clear_terms();
        for (int l = 0; l < LANES; l++) add_value(l, 5 * l + 1);
        run_case("R8", "reuse second", -1);
    endtask

    initial begin
        clear_terms();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_random();
        t_all_ones();
        t_window();
        t_negative();
        t_empty();
        t_extreme();
        t_reuse();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule